// File: doc/BRIEF.md
# Eight-bit Timer and Event Counter with Prescaler

This block is an eight-bit up-counter that serves either as an interval timer or as an event counter. Its count source is either an internal instruction tick, one in every four system clocks, or edges of one chosen polarity on an external pin. A power-of-two prescaler with eight ratios can sit between the source and the counter. A bypass bit hands the prescaler to the watchdog, and the counter then advances once per source tick.

Software writes a six-bit configuration word, reads the count at any time and may preload any value. Preloading sets the delay to the next wrap. For example, 131 with a 1:8 ratio leaves 125 prescaled counts, which is 5 ms on a 200 kHz tick. A wrap from 255 to 0 raises a one-cycle pulse for the interrupt controller.

The internal tick comes from a four-state phase sequencer. Its states are PH_Q1, PH_Q2, PH_Q3 and PH_Q4, with the transitions PH_Q1 to PH_Q2, PH_Q2 to PH_Q3, PH_Q3 to PH_Q4 and PH_Q4 to PH_Q1, one per clock. Reset places it in PH_Q1. The internal tick is high while the sequencer is in PH_Q4.

Top module: `evt_timer8`

## Requirements
- R1: While reset is active and on release, the count reads 0 and the overflow pulse is low. The configuration resets to 0: internal source, rising edge, prescaler assigned to the timer at 1:2.
- R2: On the internal source, the source ticks at the 4th, 8th, 12th, ... rising clock edge after reset release. The phase sequencer runs freely and never restarts.
- R3: On the external source, the pin passes through a two-flop synchronizer. If the pin changes between clock edges k-1 and k and the change has the selected polarity, the source ticks at edge k+2. Changes of the other polarity are ignored. Any pin activity is ignored while the internal source is selected.
- R4: With the bypass bit set, every source tick advances the count by one, and the prescaler's count holds its value.
- R5: With the bypass bit clear, rate code n gives a ratio of 2^(n+1), from 1:2 for code 000 up to 1:256 for code 111. The counter advances on the source tick that completes each group. Code 010 gives 1:8, so a preload of 131 overflows after 1000 source ticks.
- R6: A counter write loads the write data at that clock edge and clears the prescaler's count, so the next advance needs a full group. The write takes priority over an advance in the same cycle, and that cycle produces no overflow pulse.
- R7: An advance from 255 wraps the count to 0. The overflow pulse is high for exactly the one cycle in which the count first reads 0.
- R8: A configuration write applies from the cycle after its clock edge. The bit fields are: bit 5 selects the source (1 = external pin), bit 4 selects the edge (1 = falling), bit 3 is the bypass bit (1 = prescaler assigned away), and bits 2:0 hold the rate code.
- R9: The read port always shows the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | 1 | External event pin, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration word (R8 layout) |
| cnt_we | input | 1 | Counter preload strobe |
| cnt_wdata | input | 8 | Counter preload value |
| cnt_rdata | output | 8 | Current count |
| ovf_pulse | output | 1 | One-cycle wrap pulse |

## Verification
The assertions assume that the strobes and data inputs are stable around each rising edge. They also assume the external pin is sampled only through the synchronizer, so an edge that lasts less than one clock may be lost. The stimulus changes every input only at falling clock edges. It holds each external pin level for several clocks, so every pin transition reaches the edge detector. Preloads are issued on consecutive cycles so that at least one of them lands on a cycle where the source and prescaler would also advance the count.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int RATE_W = 3;
    localparam int PRE_W  = 1 << RATE_W;

    typedef enum logic [1:0] {
        PH_Q1,
        PH_Q2,
        PH_Q3,
        PH_Q4
    } phase_e;

    typedef struct packed {
        logic              src_ext;
        logic              edge_fall;
        logic              pre_bypass;
        logic [RATE_W-1:0] rate;
    } tmr_cfg_t;

    localparam int CFG_W = $bits(tmr_cfg_t);
endpackage

// File: rtl/tmr8_src.sv
module tmr8_src
    import tmr8_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic src_ext,
    input  logic edge_fall,
    output logic src_tick
);
    phase_e state_q, state_d;
    logic   int_tick;
    logic   ext_tick;
    logic [SYNC_N:0] sync_q;
    logic   now_lvl, prev_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_Q1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_Q1: state_d = PH_Q2;
            PH_Q2: state_d = PH_Q3;
            PH_Q3: state_d = PH_Q4;
            PH_Q4: state_d = PH_Q1;
        endcase
    end

    always_comb begin
        int_tick = (state_q == PH_Q4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-1:0], ext_pin};
    end

    assign now_lvl  = sync_q[SYNC_N-1];
    assign prev_lvl = sync_q[SYNC_N];
    assign ext_tick = edge_fall ? (!now_lvl && prev_lvl) : (now_lvl && !prev_lvl);
    assign src_tick = src_ext ? ext_tick : int_tick;

    // R2: the phase sequence closes after the tick phase
    p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_Q4) |=> (state_q == PH_Q1));
    // R2: an internal tick is never followed by another
    p_int_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_tick |=> !int_tick);
endmodule

// File: rtl/tmr8_presc.sv
module tmr8_presc
    import tmr8_pkg::*;
#(
    parameter int RW = RATE_W,
    localparam int PW = 1 << RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic          bypass,
    input  logic [RW-1:0] rate,
    input  logic          clr,
    output logic          cnt_tick
);
    localparam logic [PW-1:0] PRE_ONE = 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            mask[i] = (i <= int'(rate));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_q <= '0;
        else if (clr)                 pre_q <= '0;
        else if (src_tick && !bypass) pre_q <= pre_q + PRE_ONE;
    end

    assign cnt_tick = bypass ? src_tick : (src_tick && ((pre_q & mask) == mask));

    // R6: a preload empties the prescaler
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
    // R4: an assigned-away prescaler holds its count
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    localparam logic [CW-1:0] CNT_ONE = 1;

    logic [CW-1:0] cnt_q;
    logic          ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= tick && !we && (cnt_q == '1);
            if (we)        cnt_q <= wdata;
            else if (tick) cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt = cnt_q;
    assign ovf = ovf_q;

    // R6: preload wins and lands next cycle
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cnt_q == $past(wdata)));
    // R7: the pulse coincides with a zero count
    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));
    // R7: the pulse lasts one cycle
    p_wrap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);
    // R4: no write and no tick leaves the count alone
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             ovf_pulse
);
    tmr_cfg_t cfg_q;
    logic     src_tick;
    logic     cnt_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= tmr_cfg_t'(cfg_wdata);
    end

    tmr8_src #(.SYNC_N(2)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .src_ext   (cfg_q.src_ext),
        .edge_fall (cfg_q.edge_fall),
        .src_tick  (src_tick)
    );

    tmr8_presc #(.RW(RATE_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .bypass   (cfg_q.pre_bypass),
        .rate     (cfg_q.rate),
        .clr      (cnt_we),
        .cnt_tick (cnt_tick)
    );

    tmr8_count #(.CW(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cnt_we),
        .wdata (cnt_wdata),
        .tick  (cnt_tick),
        .cnt   (cnt_rdata),
        .ovf   (ovf_pulse)
    );

    // R8: a configuration write is captured whole
    p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_wdata)));
endmodule

// File: tb/evt_timer8_test.sv
module evt_timer8_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_wdata = '0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rdata;
    logic       ovf_pulse;

    always #5 clk = ~clk;

    evt_timer8 uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .ovf_pulse(ovf_pulse)
    );

    typedef struct {
        int         at_edge;
        logic [7:0] cnt;
        logic       ovf;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    edge_no = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic  ext_lvl = 1'b0;

    // reference state built from the requirements
    int         m_ph = 0;
    logic       m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic [7:0] m_pre = 0;
    logic [7:0] m_cnt = 0;
    logic       m_ext = 0, m_fall = 0, m_byp = 0;
    int         m_rate = 0;

    always @(posedge clk) edge_no <= edge_no + 1;

    // monitor: every compare also covers R9 (read port equals count)
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].at_edge <= edge_no) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (cnt_rdata !== e.cnt || ovf_pulse !== e.ovf) begin
                n_bad++;
                $display("FAIL %s R9 edge %0d: cnt=%0d ovf=%0b expected cnt=%0d ovf=%0b",
                         e.tag, e.at_edge, cnt_rdata, ovf_pulse, e.cnt, e.ovf);
            end
        end
    end

    task automatic step(input bit cwe, input logic [5:0] cd,
                        input bit wwe, input logic [7:0] wd);
        bit   itk, etk, stk, ctk, n_ovf;
        int   mask;
        exp_t e;
        cfg_we = cwe; cfg_wdata = cd; cnt_we = wwe; cnt_wdata = wd; ext_pin = ext_lvl;
        itk   = (m_ph == 3);
        etk   = m_fall ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
        stk   = m_ext ? etk : itk;
        mask  = (1 << (m_rate + 1)) - 1;
        ctk   = m_byp ? stk : (stk && ((int'(m_pre) & mask) == mask));
        n_ovf = ctk && !wwe && (m_cnt == 8'hFF);
        if (wwe) begin
            m_cnt = wd; m_pre = 0;
        end else begin
            if (ctk) m_cnt = m_cnt + 8'd1;
            if (stk && !m_byp) m_pre = m_pre + 8'd1;
        end
        if (cwe) begin
            m_ext = cd[5]; m_fall = cd[4]; m_byp = cd[3]; m_rate = int'(cd[2:0]);
        end
        m_ph = (m_ph + 1) % 4;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_lvl;
        e.at_edge = edge_no + 1; e.cnt = m_cnt; e.ovf = n_ovf; e.tag = cur_tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0);
    endtask

    task automatic toggles(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            ext_lvl = ~ext_lvl;
            idle(gap);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        n_cmp++;
        if (cnt_rdata !== 8'd0 || ovf_pulse !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: cnt=%0d ovf=%0b expected cnt=0 ovf=0", cnt_rdata, ovf_pulse);
        end
        rst_n = 1'b1;
        cur_tag = "R1 R2 R5 default 1:2";
        idle(40);
        cur_tag = "R4 R8 bypass internal";
        step(1, 6'b001000, 0, '0);
        idle(30);
        cur_tag = "R7 wrap";
        step(0, '0, 1, 8'd250);
        idle(40);
        cur_tag = "R6 preload priority and prescaler clear";
        step(1, 6'b000001, 0, '0);
        idle(5);
        for (int i = 0; i < 9; i++) step(0, '0, 1, 8'(10 + i));
        idle(40);
        cur_tag = "R5 1:8 preload 131";
        step(1, 6'b000010, 1, 8'd131);
        idle(4010);
        cur_tag = "R5 1:256";
        step(1, 6'b000111, 1, 8'd254);
        idle(2060);
        cur_tag = "R3 external rising";
        step(1, 6'b101000, 1, 8'd0);
        toggles(8, 5);
        cur_tag = "R3 external falling";
        step(1, 6'b111000, 0, '0);
        toggles(8, 4);
        cur_tag = "R3 R5 external with 1:2";
        step(1, 6'b100000, 0, '0);
        toggles(12, 3);
        cur_tag = "R3 pin ignored on internal";
        step(1, 6'b001000, 1, 8'd100);
        toggles(10, 3);
        cur_tag = "R8 back to external rising";
        step(1, 6'b101000, 1, 8'd253);
        toggles(10, 3);
        idle(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule